// File: doc/BRIEF.md
# DRAM Maintenance Timer Unit

This block holds the housekeeping timers that sit beside the scheduler of a DDR memory controller. A free-running interval counter raises refresh requests at a programmable spacing. Each bank has an idle timer that asks for an automatic precharge once an open bank has gone untouched for a programmable time with nothing queued for it. A lockout counter holds off every new command for a programmable number of clocks after a command goes out on the bypass path, because the usual per-command timing checks are not applied to such commands.

All three times come from one 32-bit configuration word. The word is written through a write-enable strobe, can be read back, and resets to zero. A zero in the refresh or idle field turns that function off. The scheduler answers the refresh and precharge requests with grant strobes, and reports bank state, accesses and queued requests each cycle. Everything runs on a single clock.

Top module: `dram_maint_timer`

## Requirements
- R1: The configuration word resets to zero, loads all 32 bits on a clock edge with `cfg_we_i` high, and reads back on `cfg_rdata_o`. The fields are: bits [31:16] refresh interval N, bits [15:8] bypass lockout L, bits [7:0] bank idle timeout T.
- R2: A configuration write restarts the refresh interval and clears any owed refresh. With N non-zero, `ref_req_o` rises N edges after the write edge. If each request is granted promptly, it rises again every N edges.
- R3: If a refresh grant is late, the interval counter keeps running and saves at most one extra owed refresh. The request stays high until every owed refresh has been granted, one per grant.
- R4: With N zero, no refresh request is made, and a request already raised drops one edge after the zero value takes effect.
- R5: A `byp_cmd_i` strobe holds `cmd_en_o` low for exactly L clocks, starting after the strobe edge. With L zero, `cmd_en_o` never drops.
- R6: For an open bank with no access and no queued request, `pre_req_o[b]` rises T edges after the last edge that saw an access to that bank.
- R7: An access, or a queued request, to a bank reloads that bank's idle timer. The timer does not run while a request is queued.
- R8: A closed bank never requests precharge. A raised request drops on the edge after the bank is seen closed.
- R9: `pre_gnt_i[b]` clears `pre_req_o[b]` on the next edge.
- R10: With T zero, no precharge request is made.
- R11: Each bank's idle timer runs independently of the other banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read back |
| ref_gnt_i | input | 1 | Refresh grant (one owed refresh served) |
| ref_req_o | output | 1 | Refresh request |
| bank_open_i | input | NB | Bank has an open row |
| bank_acc_i | input | NB | Bank accessed this cycle |
| bank_pend_i | input | NB | Request queued for bank |
| pre_gnt_i | input | NB | Precharge grant per bank |
| pre_req_o | output | NB | Idle precharge request per bank |
| byp_cmd_i | input | 1 | Command issued on bypass path |
| cmd_en_o | output | 1 | New commands allowed |

## Verification
The hardest situation to reach is a saturated refresh debt: the request must already be high, more than one further interval must pass without a grant, and then the grants must drain the debt one at a time. The bench sets a short interval, withholds the grant across two more intervals, and grants twice. It checks that the request stays up after the first grant, drops after the second, and that the next interval still arrives on the original schedule. The idle timers are swept over several timeouts, with accesses and queued requests reloading them partway through the count.

// File: rtl/dram_maint_pkg.sv
package dram_maint_pkg;
  localparam int unsigned CFG_W = 32;
  localparam int unsigned REF_W = 16;
  localparam int unsigned LCK_W = 8;
  localparam int unsigned IDL_W = 8;

  typedef struct packed {
    logic [REF_W-1:0] ref_ival;
    logic [LCK_W-1:0] lock_cyc;
    logic [IDL_W-1:0] idle_cyc;
  } maint_cfg_t;
endpackage

// File: rtl/maint_refresh_timer.sv
module maint_refresh_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic [W-1:0] ival_i,
  input  logic         gnt_i,
  output logic         req_o
);
  logic [W-1:0] cnt_q;
  logic [1:0]   owed_q, owed_d;
  logic         en, tick;
  logic [2:0]   sum;

  assign en   = (ival_i != '0);
  assign tick = en && (cnt_q == ival_i - W'(1));

  always_comb begin
    sum = {1'b0, owed_q} + {2'b0, tick} - {2'b0, (gnt_i && owed_q != 2'd0)};
    owed_d = (sum > 3'd2) ? 2'd2 : sum[1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      owed_q <= '0;
    end else begin
      if (restart_i || !en || tick) cnt_q <= '0;
      else                          cnt_q <= cnt_q + W'(1);
      if (restart_i || !en) owed_q <= '0;
      else                  owed_q <= owed_d;
    end
  end

  assign req_o = (owed_q != 2'd0);
endmodule

// File: rtl/maint_cmd_lockout.sv
module maint_cmd_lockout #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         byp_i,
  input  logic [W-1:0] lock_i,
  output logic         cmd_en_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (byp_i)         cnt_q <= lock_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign cmd_en_o = (cnt_q == '0);
endmodule

// File: rtl/maint_bank_idle.sv
module maint_bank_idle #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         open_i,
  input  logic         acc_i,
  input  logic         pend_i,
  input  logic         gnt_i,
  input  logic [W-1:0] limit_i,
  output logic         req_o
);
  logic [W-1:0] tmr_q;
  logic         req_q, run, expired;

  assign run     = open_i && !acc_i && !pend_i && (limit_i != '0);
  assign expired = (tmr_q >= limit_i - W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q <= '0;
      req_q <= 1'b0;
    end else if (!run || gnt_i) begin
      tmr_q <= '0;
      req_q <= 1'b0;
    end else if (expired) begin
      req_q <= 1'b1;
    end else begin
      tmr_q <= tmr_q + W'(1);
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/dram_maint_timer.sv
module dram_maint_timer
  import dram_maint_pkg::*;
#(
  parameter int unsigned NB = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [31:0]   cfg_wdata_i,
  output logic [31:0]   cfg_rdata_o,
  input  logic          ref_gnt_i,
  output logic          ref_req_o,
  input  logic [NB-1:0] bank_open_i,
  input  logic [NB-1:0] bank_acc_i,
  input  logic [NB-1:0] bank_pend_i,
  input  logic [NB-1:0] pre_gnt_i,
  output logic [NB-1:0] pre_req_o,
  input  logic          byp_cmd_i,
  output logic          cmd_en_o
);
  maint_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cfg_q <= '0;
    else if (cfg_we_i) cfg_q <= maint_cfg_t'(cfg_wdata_i);
  end

  assign cfg_rdata_o = CFG_W'(cfg_q);

  maint_refresh_timer #(.W(REF_W)) u_ref (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (cfg_we_i),
    .ival_i    (cfg_q.ref_ival),
    .gnt_i     (ref_gnt_i),
    .req_o     (ref_req_o)
  );

  maint_cmd_lockout #(.W(LCK_W)) u_lock (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .byp_i    (byp_cmd_i),
    .lock_i   (cfg_q.lock_cyc),
    .cmd_en_o (cmd_en_o)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    maint_bank_idle #(.W(IDL_W)) u_idle (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .open_i  (bank_open_i[b]),
      .acc_i   (bank_acc_i[b]),
      .pend_i  (bank_pend_i[b]),
      .gnt_i   (pre_gnt_i[b]),
      .limit_i (cfg_q.idle_cyc),
      .req_o   (pre_req_o[b])
    );
  end
endmodule

module dram_maint_timer_chk #(
  parameter int unsigned NB = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cfg_we_i,
  input logic [31:0]   cfg_rdata_o,
  input logic          ref_gnt_i,
  input logic          ref_req_o,
  input logic [NB-1:0] bank_open_i,
  input logic [NB-1:0] bank_acc_i,
  input logic [NB-1:0] bank_pend_i,
  input logic [NB-1:0] pre_gnt_i,
  input logic [NB-1:0] pre_req_o,
  input logic          byp_cmd_i,
  input logic          cmd_en_o
);
  // R3
  ref_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_req_o && !ref_gnt_i && !cfg_we_i && cfg_rdata_o[31:16] != 16'd0) |=> ref_req_o);
  // R4
  ref_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[31:16] == 16'd0) |=> !ref_req_o);
  // R5
  lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byp_cmd_i && cfg_rdata_o[15:8] != 8'd0) |=> !cmd_en_o);
  // R5
  lock_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byp_cmd_i && cfg_rdata_o[15:8] == 8'd0) |=> cmd_en_o);
  // R8
  pre_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pre_req_o & $past(pre_gnt_i | ~bank_open_i | bank_acc_i | bank_pend_i)) == '0));
  // R10
  idle_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_rdata_o[7:0] == 8'd0) |=> (pre_req_o == '0));
endmodule

bind dram_maint_timer dram_maint_timer_chk #(.NB(NB)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_rdata_o (cfg_rdata_o),
  .ref_gnt_i   (ref_gnt_i),
  .ref_req_o   (ref_req_o),
  .bank_open_i (bank_open_i),
  .bank_acc_i  (bank_acc_i),
  .bank_pend_i (bank_pend_i),
  .pre_gnt_i   (pre_gnt_i),
  .pre_req_o   (pre_req_o),
  .byp_cmd_i   (byp_cmd_i),
  .cmd_en_o    (cmd_en_o)
);

// File: tb/dram_maint_timer_tb.sv
module dram_maint_timer_tb_top;
  localparam int NB = 8;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cfg_we_i = 1'b0;
  logic [31:0]   cfg_wdata_i = '0;
  logic [31:0]   cfg_rdata_o;
  logic          ref_gnt_i = 1'b0;
  logic          ref_req_o;
  logic [NB-1:0] bank_open_i = '0;
  logic [NB-1:0] bank_acc_i = '0;
  logic [NB-1:0] bank_pend_i = '0;
  logic [NB-1:0] pre_gnt_i = '0;
  logic [NB-1:0] pre_req_o;
  logic          byp_cmd_i = 1'b0;
  logic          cmd_en_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  dram_maint_timer #(.NB(NB)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
    .cfg_rdata_o(cfg_rdata_o), .ref_gnt_i(ref_gnt_i), .ref_req_o(ref_req_o),
    .bank_open_i(bank_open_i), .bank_acc_i(bank_acc_i), .bank_pend_i(bank_pend_i),
    .pre_gnt_i(pre_gnt_i), .pre_req_o(pre_req_o), .byp_cmd_i(byp_cmd_i),
    .cmd_en_o(cmd_en_o)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input int ival, input int lck, input int idl);
    cfg_wdata_i = {ival[15:0], lck[7:0], idl[7:0]};
    cfg_we_i = 1'b1;
    step();
    cfg_we_i = 1'b0;
  endtask

  // steps until bit rises, capped
  task automatic wait_ref(output int k);
    k = 0;
    while (!ref_req_o && k < 300) begin step(); k++; end
  endtask

  task automatic wait_pre(input int b, output int k);
    k = 0;
    while (!pre_req_o[b] && k < 300) begin step(); k++; end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int k;
    #23;
    // R1 reset state
    chk("R1 reset cfg", cfg_rdata_o, 0);
    chk("R1 reset ref", ref_req_o, 0);
    chk("R1 reset pre", pre_req_o, 0);
    chk("R1 reset cmd_en", cmd_en_o, 1);
    rst_ni = 1'b1;
    step();
    wr_cfg(16'hA5C3, 8'h7E, 8'h19);
    chk("R1 readback", cfg_rdata_o, 32'hA5C37E19);
    wr_cfg(0, 0, 0);
    chk("R1 readback zero", cfg_rdata_o, 0);

    // R2 interval sweep
    for (int n = 1; n <= 6; n++) begin
      wr_cfg(n, 0, 0);
      wait_ref(k);
      chk($sformatf("R2 first rise N=%0d", n), k, n);
      ref_gnt_i = 1'b1; step(); ref_gnt_i = 1'b0;
      if (n == 1) chk("R2 N=1 stays high", ref_req_o, 1);
      else begin
        chk($sformatf("R2 cleared N=%0d", n), ref_req_o, 0);
        wait_ref(k);
        chk($sformatf("R2 period N=%0d", n), k, n - 1);
      end
    end

    // R3 delayed grant, saturation at one owed
    wr_cfg(4, 0, 0);
    wait_ref(k);
    chk("R3 rise", k, 4);
    repeat (8) step();
    chk("R3 held", ref_req_o, 1);
    ref_gnt_i = 1'b1; step();
    chk("R3 owed after grant 1", ref_req_o, 1);
    step(); ref_gnt_i = 1'b0;
    chk("R3 drained after grant 2", ref_req_o, 0);
    wait_ref(k);
    chk("R3 schedule kept", k, 2);

    // R4 disable while pending
    wr_cfg(0, 0, 0);
    step();
    chk("R4 drop", ref_req_o, 0);
    k = 0;
    repeat (20) begin step(); k += ref_req_o; end
    chk("R4 silent", k, 0);

    // R5 lockout sweep
    for (int l = 0; l <= 5; l++) begin
      wr_cfg(0, l, 0);
      byp_cmd_i = 1'b1; step(); byp_cmd_i = 1'b0;
      chk($sformatf("R5 first L=%0d", l), cmd_en_o, (l == 0) ? 1 : 0);
      k = 0;
      while (!cmd_en_o && k < 300) begin step(); k++; end
      chk($sformatf("R5 low cycles L=%0d", l), k, l);
    end

    // R6 + R9 timeout sweep per bank
    for (int t = 1; t <= 5; t++) begin
      for (int b = 0; b < NB; b += 3) begin
        wr_cfg(0, 0, t);
        bank_open_i = '0; step();
        bank_open_i = '1;
        bank_acc_i[b] = 1'b1; step(); bank_acc_i = '0;
        wait_pre(b, k);
        chk($sformatf("R6 T=%0d bank %0d", t, b), k, t);
        pre_gnt_i[b] = 1'b1; step(); pre_gnt_i = '0;
        chk($sformatf("R9 grant clear T=%0d bank %0d", t, b), pre_req_o[b], 0);
      end
    end

    // R7 reload by access and by queued request
    wr_cfg(0, 0, 4);
    bank_open_i = '0; step();
    bank_open_i = '1;
    bank_acc_i[1] = 1'b1; step(); bank_acc_i = '0;
    step(); step();
    bank_acc_i[1] = 1'b1; step(); bank_acc_i = '0;
    wait_pre(1, k);
    chk("R7 access reload", k, 4);
    pre_gnt_i[1] = 1'b1; bank_pend_i[1] = 1'b1; step(); pre_gnt_i = '0;
    k = 0;
    repeat (10) begin step(); k += pre_req_o[1]; end
    chk("R7 pending holds", k, 0);
    bank_pend_i = '0;
    wait_pre(1, k);
    chk("R7 pending reload", k, 4);

    // R8 closed bank
    wr_cfg(0, 0, 2);
    bank_open_i = '0;
    k = 0;
    repeat (20) begin step(); k += (pre_req_o != '0); end
    chk("R8 closed silent", k, 0);
    bank_open_i[6] = 1'b1;
    wait_pre(6, k);
    chk("R8 open then rise", k, 2);
    bank_open_i[6] = 1'b0; step();
    chk("R8 close drops", pre_req_o[6], 0);

    // R10 timeout zero
    wr_cfg(0, 0, 0);
    bank_open_i = '1;
    bank_acc_i = '1; step(); bank_acc_i = '0;
    k = 0;
    repeat (30) begin step(); k += (pre_req_o != '0); end
    chk("R10 disabled", k, 0);

    // R11 independent banks
    wr_cfg(0, 0, 3);
    bank_open_i = '0; step();
    bank_open_i = '1;
    bank_acc_i = 8'b0000_0100; step();
    bank_acc_i = '0; step();
    bank_acc_i = 8'b0010_0000; step();
    bank_acc_i = '0;
    step();
    chk("R11 bank2 early", pre_req_o[2], 1);
    chk("R11 bank5 not yet", pre_req_o[5], 0);
    step(); step();
    chk("R11 bank5 later", pre_req_o[5], 1);

    finish_run();
  end
endmodule